// File: doc/BRIEF.md
# Gated Edge-Triggered One-Shot Timer

This block is a clocked monostable pulse generator. Two trigger inputs and an active-low clear act on it. An accepted trigger loads a 16-bit width value into a down-counter. The true output stays high for that many system clocks, and the complementary output mirrors it inverted. A counter in the clock domain takes the place of the resistor-capacitor network that sets the width of an analog one-shot.

One trigger input fires on its falling edge, but only while the other trigger input is high. The other fires on its rising edge, but only while the first is low. All three inputs may be asynchronous. Each passes through a two-flop synchroniser before edge detection. A build-time switch selects whether a trigger that arrives during an active pulse restarts the interval or is ignored. A second switch lets the rising edge of the clear line start a pulse when the trigger inputs already stand in their armed levels.

Typical uses are pulse stretching, missing-event watchdogs in retriggerable form, and fixed-length strobes from edges of any duration.

Top module: `mono_pulse_timer`

## Requirements
- R1: While `rst_n` is low, and after reset until a trigger is accepted, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: With `clr_n_i` and `trig_rise_i` high, a 1-to-0 change on `trig_fall_i` makes `pulse_o` rise on the third rising clock edge after the change.
- R3: With `clr_n_i` high and `trig_fall_i` low, a 0-to-1 change on `trig_rise_i` makes `pulse_o` rise on the third rising clock edge after the change.
- R4: An accepted trigger with width value W (sampled from `width_i` at the edge where the pulse starts) holds `pulse_o` high for exactly W clock cycles, whether the trigger input stays asserted for one cycle or for longer than W.
- R5: A trigger that arrives while `width_i` is 0 is not accepted. It starts no pulse and does not change a pulse in progress.
- R6: A 1-to-0 change on `clr_n_i` forces `pulse_o` low on the third rising edge after the change and ends any pulse in progress. While the synchronised clear is low, no trigger is accepted.
- R7: With `RETRIG`=1, an accepted trigger during an active pulse reloads the full width. The pulse then ends W cycles after the last accepted trigger.
- R8: With `RETRIG`=0, triggers that arrive while the pulse is active are ignored, and the pulse ends W cycles after the trigger that started it.
- R9: With `CLR_TRIG`=1, a 0-to-1 change on `clr_n_i` while `trig_rise_i` is high and `trig_fall_i` is low starts a pulse on the third rising edge after the change. With `trig_fall_i` high it starts none.
- R10: With `CLR_TRIG`=0, a rising clear edge never starts a pulse. It can only end or shorten one.
- R11: `pulse_n_o` is the logical complement of `pulse_o` in every cycle.
- R12: Edges that fail their gating start nothing. A falling `trig_fall_i` while `trig_rise_i` is low does not trigger, and a rising `trig_rise_i` while `trig_fall_i` is high does not trigger. An input held at a fixed level never re-triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_fall_i | input | 1 | Trigger on falling edge, gated by `trig_rise_i` high |
| trig_rise_i | input | 1 | Trigger on rising edge, gated by `trig_fall_i` low |
| clr_n_i | input | 1 | Active-low clear; optional trigger on release |
| width_i | input | CNT_W | Pulse width in clock cycles, sampled on acceptance |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |

## Verification
Every input change reaches the outputs on the third rising edge after it: two synchroniser flops, then the counter and output flop. The width value takes effect on the edge where the pulse starts. The bench changes inputs just after a falling edge. A reference model pushes each edge's input sample into a queue and computes the counter from the entries two and three edges old, which reproduces the three-edge latency without mirroring the RTL. The outputs of a retriggerable instance and of a non-retriggerable, clear-release instance are compared with the model at every falling edge. A pulse of W cycles is therefore seen as exactly W high samples.

// File: rtl/mono_pkg.sv
`timescale 1ns/1ps
package mono_pkg;

  // synchronised level and its value one clock earlier
  typedef struct packed {
    logic lvl;
    logic prev;
  } pin_t;

  localparam int PIN_A   = 0;  // falling-edge trigger
  localparam int PIN_B   = 1;  // rising-edge trigger
  localparam int PIN_CLR = 2;  // active-low clear
  localparam int NPINS   = 3;

endpackage

// File: rtl/mono_sync.sv
`timescale 1ns/1ps
module mono_sync #(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  output mono_pkg::pin_t  line_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o.lvl  = chain_q[STAGES-1];
  assign line_o.prev = prev_q;

endmodule

// File: rtl/mono_gate.sv
`timescale 1ns/1ps
module mono_gate #(
  parameter bit CLR_TRIG = 1'b0
) (
  input  mono_pkg::pin_t a_i,
  input  mono_pkg::pin_t b_i,
  input  mono_pkg::pin_t c_i,
  output logic           trig_o
);

  localparam logic REL_EN = CLR_TRIG;

  logic fall_a;
  logic rise_b;
  logic rise_c;
  logic rel;

  always_comb begin
    fall_a = a_i.prev & ~a_i.lvl;
    rise_b = ~b_i.prev & b_i.lvl;
    rise_c = ~c_i.prev & c_i.lvl;
    // release of clear counts only in the variant that allows it
    rel    = REL_EN & rise_c & b_i.lvl & ~a_i.lvl;
    trig_o = c_i.lvl & ((fall_a & b_i.lvl) | (rise_b & ~a_i.lvl) | rel);
  end

endmodule

// File: rtl/mono_count.sv
`timescale 1ns/1ps
module mono_count #(
  parameter int CNT_W  = 16,
  parameter bit RETRIG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_lvl,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             busy_q;
  logic             may_load;
  logic             load;
  logic             cnt_en;

  generate
    if (RETRIG) begin : g_retrig
      assign may_load = 1'b1;
    end else begin : g_once
      assign may_load = (cnt_q == '0);
    end
  endgenerate

  always_comb begin
    load    = trig_i & (width_i != '0) & may_load;
    cnt_en  = load | (cnt_q != '0);
    cnt_nxt = cnt_q;
    if (!clr_lvl) begin
      cnt_nxt = '0;
    end else if (load) begin
      cnt_nxt = width_i;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_nxt;
      busy_q <= (cnt_nxt != '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/mono_pulse_timer.sv
`timescale 1ns/1ps
module mono_pulse_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit RETRIG      = 1'b1,
  parameter bit CLR_TRIG    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clr_n_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  import mono_pkg::*;

  logic [NPINS-1:0] raw_in;
  pin_t             pins [NPINS];
  logic             clr_lvl;
  logic             trig_raw;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign raw_in = {clr_n_i, trig_rise_i, trig_fall_i};

  generate
    for (genvar gi = 0; gi < NPINS; gi++) begin : g_sync
      mono_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (raw_in[gi]),
        .line_o (pins[gi])
      );
    end
  endgenerate

  assign clr_lvl = pins[PIN_CLR].lvl;

  mono_gate #(.CLR_TRIG(CLR_TRIG)) u_gate (
    .a_i    (pins[PIN_A]),
    .b_i    (pins[PIN_B]),
    .c_i    (pins[PIN_CLR]),
    .trig_o (trig_raw)
  );

  mono_count #(.CNT_W(CNT_W), .RETRIG(RETRIG)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_lvl (clr_lvl),
    .trig_i  (trig_raw),
    .width_i (width_i),
    .cnt_o   (cnt),
    .busy_o  (busy)
  );

  assign pulse_o   = busy;
  assign pulse_n_o = ~busy;

endmodule

// File: rtl/mono_pulse_timer_chk.sv
`timescale 1ns/1ps
module mono_pulse_timer_chk #(
  parameter int CNT_W  = 16,
  parameter bit RETRIG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_lvl,
  input logic             trig_raw,
  input logic [CNT_W-1:0] width_i,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse_o,
  input logic             pulse_n_o
);

  p_comp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_n_o == !pulse_o);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(trig_raw));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lvl |=> (!pulse_o && cnt == '0));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_raw && width_i == '0 && !pulse_o) |=> !pulse_o);

  generate
    if (RETRIG) begin : g_re
      p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_raw && width_i != '0) |=> cnt == $past(width_i));
    end else begin : g_once
      p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && trig_raw) |=> cnt == $past(cnt) - 1'b1);
    end
  endgenerate

endmodule

bind mono_pulse_timer mono_pulse_timer_chk #(
  .CNT_W  (CNT_W),
  .RETRIG (RETRIG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_lvl   (clr_lvl),
  .trig_raw  (trig_raw),
  .width_i   (width_i),
  .cnt       (cnt),
  .pulse_o   (pulse_o),
  .pulse_n_o (pulse_n_o)
);

// File: tb/test_mono_pulse_timer.sv
`timescale 1ns/1ps
module test_mono_pulse_timer;

  logic        clk;
  logic        rst_n;
  logic        a;
  logic        b;
  logic        cl;
  logic [15:0] w;
  logic        p0, pn0, p1, pn1;

  int    vec;
  int    bad;
  bit    done;
  string tag;
  int    m0, m1;
  bit    qa[$];
  bit    qb[$];
  bit    qc[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // retriggerable, clear release does not trigger
  mono_pulse_timer #(.RETRIG(1'b1), .CLR_TRIG(1'b0)) i_mono_pulse_timer (
    .clk(clk), .rst_n(rst_n), .trig_fall_i(a), .trig_rise_i(b),
    .clr_n_i(cl), .width_i(w), .pulse_o(p0), .pulse_n_o(pn0));

  // non-retriggerable, clear release may trigger
  mono_pulse_timer #(.RETRIG(1'b0), .CLR_TRIG(1'b1)) i_mono_pulse_timer_alt (
    .clk(clk), .rst_n(rst_n), .trig_fall_i(a), .trig_rise_i(b),
    .clr_n_i(cl), .width_i(w), .pulse_o(p1), .pulse_n_o(pn1));

  // reference model: index 2 is the sample two edges old, index 3 three
  function automatic int step(int c, bit rt, bit ct, int wid);
    bit a0, a1, b0, b1, c0, c1, trig;
    a0 = qa[2]; a1 = qa[3];
    b0 = qb[2]; b1 = qb[3];
    c0 = qc[2]; c1 = qc[3];
    if (!c0) return 0;
    trig = (a1 && !a0 && b0) || (!b1 && b0 && !a0) || (ct && !c1 && b0 && !a0);
    if (trig && wid != 0 && (rt || c == 0)) return wid;
    if (c > 0) return c - 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa = '{0, 0, 0, 0};
      qb = '{0, 0, 0, 0};
      qc = '{0, 0, 0, 0};
      m0 = 0;
      m1 = 0;
    end else begin
      qa.push_front(a); void'(qa.pop_back());
      qb.push_front(b); void'(qb.pop_back());
      qc.push_front(cl); void'(qc.pop_back());
      m0 = step(m0, 1'b1, 1'b0, int'(w));
      m1 = step(m1, 1'b0, 1'b1, int'(w));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(p0 == 1'b0 && pn0 == 1'b1, "R1 (dut0 in reset)", p0, 0);
        chk(p1 == 1'b0 && pn1 == 1'b1, "R1 (dut1 in reset)", p1, 0);
      end else begin
        chk(p0 == (m0 != 0), {tag, " retrig"}, p0, int'(m0 != 0));
        chk(p1 == (m1 != 0), {tag, " once"}, p1, int'(m1 != 0));
        chk(pn0 == !p0, "R11 dut0", pn0, int'(!p0));
        chk(pn1 == !p1, "R11 dut1", pn1, int'(!p1));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    vec = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; a = 1'b1; b = 1'b0; cl = 1'b1; w = 16'd5;
    tag = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(6);

    // R2: falling A with B high
    tag = "R2";
    b = 1'b1; idle(3);
    a = 1'b0; idle(12);
    a = 1'b1; b = 1'b0; idle(4);

    // R3: rising B with A low
    tag = "R3";
    a = 1'b0; idle(3);
    b = 1'b1; idle(12);
    b = 1'b0; idle(3);

    // R4: width independent of trigger hold time
    tag = "R4";
    w = 16'd7; b = 1'b1; idle(30);
    b = 1'b0; idle(3);
    w = 16'd1; b = 1'b1; idle(1);
    b = 1'b0; idle(6);

    // R5: zero width
    tag = "R5";
    w = 16'd0; b = 1'b1; idle(10);
    b = 1'b0; idle(3);

    // R7 R8: triggers during an active pulse
    tag = "R7 R8";
    w = 16'd10;
    b = 1'b1; idle(1); b = 1'b0; idle(4);
    b = 1'b1; idle(1); b = 1'b0; idle(4);
    b = 1'b1; idle(1); b = 1'b0; idle(20);

    // R6: clear ends a pulse and blocks triggers
    tag = "R6";
    w = 16'd12;
    b = 1'b1; idle(1); b = 1'b0; idle(4);
    cl = 1'b0; idle(3);
    b = 1'b1; idle(1); b = 1'b0; idle(3);
    cl = 1'b1; idle(16);

    // R9 R10: clear release with B high, A low; then with A high
    tag = "R9 R10";
    w = 16'd6;
    cl = 1'b0; idle(3);
    b = 1'b1; idle(4);
    cl = 1'b1; idle(12);
    cl = 1'b0; a = 1'b1; idle(4);
    cl = 1'b1; idle(10);
    b = 1'b0; idle(3);

    // R12: ungated edges
    tag = "R12";
    a = 1'b0; idle(6);
    a = 1'b1; idle(3);
    b = 1'b1; idle(8);
    b = 1'b0; idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule